// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Port

This block moves one byte at a time over a clock line, a serial input and a serial output. A two-bit mode field picks the shift clock. It can come from an external clock pin, from the level of a timer toggle flip-flop, or from one of two prescaled system-clock ticks. In the three internal modes the block generates the serial clock itself and drives the clock pin. In the external mode that pin is only an input. It passes through a synchronizer before its edges are detected.

A write to the shift register while the port is idle is the start request. The first falling serial-clock edge after that opens the first bit period. Output bits change on falling edges and input bits are captured on rising edges, most significant bit first in both directions. After the eighth rising edge the clock is masked, the shift register holds the received byte, and the completion flag is raised. Between transfers, two command strobes force the data-out latch high or low.

Top module: `sio3_port`

## Requirements
- R1: Mode encoding: 2'b00 = external clock pin, 2'b01 = timer toggle level (each change is one clock step), 2'b10 = divide-by-16 tick, 2'b11 = divide-by-8 tick. `sck_oe` is 1 only when enabled and the mode is not 2'b00.
- R2: A write while enabled and idle loads `wdata` and starts a transfer. On the next clock `so` shows `wdata[7]`.
- R3: Transmitted bits leave `so` MSB first. A new bit appears after each falling serial-clock edge except the first, and is stable across the following rising edge.
- R4: `si` is sampled on each rising serial-clock edge and shifted in at bit 0. After eight rising edges `rdata` holds the byte received MSB first.
- R5: A transfer produces exactly eight serial-clock periods. The internal clock then stays masked high, whatever ticks still arrive.
- R6: `irq` is set when the eighth bit completes. It stays set until `irq_clr` is pulsed or a new start write occurs.
- R7: A write to the shift register during a transfer is ignored, and the transfer finishes with its original data.
- R8: When idle, `so_set` drives `so` to 1 and `so_clr` drives it to 0. Both strobes are ignored during a transfer.
- R9: With `enable` low no transfer starts and writes leave `rdata` unchanged. Dropping `enable` mid-transfer aborts it without raising `irq` and returns `sck_out` high.
- R10: In each internal mode only the selected source advances the serial clock. The other tick input has no effect.
- R11: In the external mode, edges on `sck_in` drive the transfer after synchronization, and the block never drives the clock pin.
- R12: After reset `sck_out`=1, `so`=1, `irq`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable; low aborts and holds idle |
| mode | input | 2 | Shift-clock source select |
| tmr_tgl | input | 1 | Timer toggle flip-flop level |
| tick_div16 | input | 1 | One-cycle tick at system clock / 16 |
| tick_div8 | input | 1 | One-cycle tick at system clock / 8 |
| wr_en | input | 1 | Shift-register write strobe (start request) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Shift-register contents |
| so_set | input | 1 | Force data-out latch high (idle only) |
| so_clr | input | 1 | Force data-out latch low (idle only) |
| irq_clr | input | 1 | Clear completion flag |
| sck_in | input | 1 | Clock pin input value |
| sck_out | output | 1 | Clock pin drive value |
| sck_oe | output | 1 | Clock pin output enable |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| irq | output | 1 | Transfer-complete flag |

## Verification
The embedded properties assume that `mode` does not change during a transfer. They also assume that `so_set`, `so_clr` and `wr_en` strobes given mid-transfer arrive between serial-clock edges, and that the external clock's half periods are several system clocks long. The stimulus changes the mode only while the port is idle or disabled. The external clock is held for eight system cycles per level, and the prescaler ticks stay single-cycle pulses, as a real divider would give.

// File: rtl/sio3_pkg.sv
package sio3_pkg;
   typedef enum logic [1:0] {
      SRC_EXT   = 2'b00,
      SRC_TMR   = 2'b01,
      SRC_DIV16 = 2'b10,
      SRC_DIV8  = 2'b11
   } sck_src_e;
endpackage

// File: rtl/sio3_sync.sv
module sio3_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sio3_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sio3_clkgen.sv
module sio3_clkgen
   import sio3_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter bit TMR_BOTH_EDGES = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     enable,
   input  sck_src_e mode,
   input  logic     busy,
   input  logic     tmr_tgl,
   input  logic     tick_div16,
   input  logic     tick_div8,
   input  logic     sck_in,
   output logic     fall_ev,
   output logic     rise_ev,
   output logic     sck_out,
   output logic     sck_oe
);
   logic ext_lvl, ext_prev, ext_fall, ext_rise;
   logic tmr_prev, tmr_step;
   logic int_tick, int_step, sck_int, is_ext;

   sio3_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sck_in),
      .q    (ext_lvl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev <= 1'b1;
         tmr_prev <= 1'b0;
      end else begin
         ext_prev <= ext_lvl;
         tmr_prev <= tmr_tgl;
      end
   end

   assign ext_fall = ext_prev & ~ext_lvl;
   assign ext_rise = ~ext_prev & ext_lvl;

   generate
      if (TMR_BOTH_EDGES) begin : g_tmr_both
         assign tmr_step = tmr_tgl ^ tmr_prev;
      end else begin : g_tmr_rise
         assign tmr_step = tmr_tgl & ~tmr_prev;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         SRC_TMR:   int_tick = tmr_step;
         SRC_DIV16: int_tick = tick_div16;
         SRC_DIV8:  int_tick = tick_div8;
         default:   int_tick = 1'b0;
      endcase
   end

   assign is_ext   = (mode == SRC_EXT);
   assign int_step = enable & busy & ~is_ext & int_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 sck_int <= 1'b1;
      else if (!enable || is_ext) sck_int <= 1'b1;
      else if (int_step)          sck_int <= ~sck_int;
   end

   assign fall_ev = is_ext ? (enable & busy & ext_fall) : (int_step & sck_int);
   assign rise_ev = is_ext ? (enable & busy & ext_rise) : (int_step & ~sck_int);
   assign sck_out = sck_int;
   assign sck_oe  = enable & ~is_ext;

   assert_sck_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_int);
endmodule

// File: rtl/sio3_shifter.sv
module sio3_shifter #(
   parameter int   DATA_W = 8,
   parameter logic SO_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              si,
   input  logic              fall_ev,
   input  logic              rise_ev,
   input  logic              so_set,
   input  logic              so_clr,
   input  logic              irq_clr,
   output logic              busy,
   output logic [DATA_W-1:0] rdata,
   output logic              so,
   output logic              irq
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad
         $error("sio3_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sr;
   logic [CNT_W-1:0]  cnt;
   logic              started, so_q;
   logic              start, done, run;

   assign start = enable & wr_en & ~busy;
   assign run   = enable & busy;
   assign done  = run & rise_ev & started & (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr      <= '0;
         cnt     <= '0;
         busy    <= 1'b0;
         started <= 1'b0;
      end else if (!enable) begin
         busy    <= 1'b0;
         started <= 1'b0;
         cnt     <= '0;
      end else if (start) begin
         sr      <= wdata;
         busy    <= 1'b1;
         started <= 1'b0;
         cnt     <= '0;
      end else if (busy) begin
         if (fall_ev) started <= 1'b1;
         if (rise_ev && started) begin
            sr  <= {sr[MSB-1:0], si};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
               busy    <= 1'b0;
               started <= 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              so_q <= SO_RST;
      else if (start)                          so_q <= wdata[MSB];
      else if (run && fall_ev && started)      so_q <= sr[MSB];
      else if (!busy && so_set)                so_q <= 1'b1;
      else if (!busy && so_clr)                so_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  irq <= 1'b0;
      else if (done)               irq <= 1'b1;
      else if (start || irq_clr)   irq <= 1'b0;
   end

   assign rdata = sr;
   assign so    = so_q;

   assert_edges_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_ev && rise_ev));
   assert_idle_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cnt == '0));
   assert_irq_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $fell(busy));
   assert_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && !rise_ev) |=> $stable(sr));
   assert_so_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall_ev && (so_set || so_clr)) |=> $stable(so));
endmodule

// File: rtl/sio3_port.sv
module sio3_port
   import sio3_pkg::*;
#(
   parameter int   DATA_W         = 8,
   parameter int   SYNC_STAGES    = 2,
   parameter bit   TMR_BOTH_EDGES = 1'b1,
   parameter logic SO_RST         = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [1:0]        mode,
   input  logic              tmr_tgl,
   input  logic              tick_div16,
   input  logic              tick_div8,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              so_set,
   input  logic              so_clr,
   input  logic              irq_clr,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              si,
   output logic              so,
   output logic              irq
);
   logic fall_ev, rise_ev, busy;

   sio3_clkgen #(
      .SYNC_STAGES   (SYNC_STAGES),
      .TMR_BOTH_EDGES(TMR_BOTH_EDGES)
   ) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .mode      (sck_src_e'(mode)),
      .busy      (busy),
      .tmr_tgl   (tmr_tgl),
      .tick_div16(tick_div16),
      .tick_div8 (tick_div8),
      .sck_in    (sck_in),
      .fall_ev   (fall_ev),
      .rise_ev   (rise_ev),
      .sck_out   (sck_out),
      .sck_oe    (sck_oe)
   );

   sio3_shifter #(
      .DATA_W(DATA_W),
      .SO_RST(SO_RST)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .wr_en  (wr_en),
      .wdata  (wdata),
      .si     (si),
      .fall_ev(fall_ev),
      .rise_ev(rise_ev),
      .so_set (so_set),
      .so_clr (so_clr),
      .irq_clr(irq_clr),
      .busy   (busy),
      .rdata  (rdata),
      .so     (so),
      .irq    (irq)
   );

   assert_ext_pin_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> (!sck_oe && sck_out));
endmodule

// File: tb/sim_sio3_port.sv
module sim_sio3_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [1:0] mode = 2'b00;
   logic       tmr_tgl = 1'b0;
   logic       tick_div16 = 1'b0;
   logic       tick_div8 = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       so_set = 1'b0, so_clr = 1'b0, irq_clr = 1'b0;
   logic       sck_in = 1'b1;
   logic       sck_out, sck_oe, si, so, irq;

   logic       ext_drv = 1'b0;
   logic       si_ext = 1'b0;
   logic       si_mon = 1'b0;
   logic       run8 = 1'b0, run16 = 1'b0, runt = 1'b0;
   logic [7:0] slave_tx = 8'h00;
   int         base = 0;
   int         rises = 0, falls = 0, cyc = 0;
   logic       prev_sck = 1'b1;
   logic [7:0] mon_cap = 8'h00;
   int         checks = 0, failures = 0;

   assign si = ext_drv ? si_ext : si_mon;

   always #2.5 clk = ~clk;

   sio3_port u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
      .tmr_tgl(tmr_tgl), .tick_div16(tick_div16), .tick_div8(tick_div8),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .so_set(so_set), .so_clr(so_clr), .irq_clr(irq_clr),
      .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
      .si(si), .so(so), .irq(irq)
   );

   // prescaler / timer models
   always @(negedge clk) begin
      cyc = cyc + 1;
      tick_div8  = run8  && (cyc % 4 == 0);
      tick_div16 = run16 && (cyc % 8 == 0);
      if (runt && (cyc % 6 == 0)) tmr_tgl = ~tmr_tgl;
   end

   // slave model on the generated clock
   always @(negedge clk) begin
      if (prev_sck && !sck_out) begin
         falls = falls + 1;
         if (rises - base < 8) si_mon = slave_tx[7 - (rises - base)];
      end
      if (!prev_sck && sck_out) begin
         rises   = rises + 1;
         mon_cap = {mon_cap[6:0], so};
      end
      prev_sck = sck_out;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_write(input logic [7:0] d);
      wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_irq(input int limit);
      for (int i = 0; i < limit && !irq; i++) @(negedge clk);
   endtask

   task automatic set_gens(input logic [1:0] m);
      run8 = (m == 2'b11); run16 = (m == 2'b10); runt = (m == 2'b01);
   endtask

   task automatic t_reset_state;
      chk(sck_out == 1'b1, "R12", "sck_out after reset", sck_out, 1);
      chk(so == 1'b1, "R12", "so after reset", so, 1);
      chk(irq == 1'b0, "R12", "irq after reset", irq, 0);
      chk(rdata == 8'h00, "R12", "rdata after reset", rdata, 0);
   endtask

   task automatic t_so_latch;
      so_clr = 1'b1; @(negedge clk); so_clr = 1'b0;
      chk(so == 1'b0, "R8", "so after clear strobe", so, 0);
      so_set = 1'b1; @(negedge clk); so_set = 1'b0;
      chk(so == 1'b1, "R8", "so after set strobe", so, 1);
   endtask

   task automatic t_xfer_int(input logic [1:0] m, input logic [7:0] mtx,
                             input logic [7:0] stx);
      int r0;
      mode = m; slave_tx = stx; base = rises;
      set_gens(m);
      pulse_write(mtx);
      chk(so == mtx[7], "R2", "first bit on so", so, mtx[7]);
      chk(sck_oe == 1'b1, "R1", "sck_oe in internal mode", sck_oe, 1);
      wait_irq(600);
      cycles(1);
      chk(irq == 1'b1, "R6", "irq after transfer", irq, 1);
      chk(rises - base == 8, "R5", "clock periods", rises - base, 8);
      chk(mon_cap == mtx, "R3", "bits seen by slave", mon_cap, mtx);
      chk(rdata == stx, "R4", "received byte", rdata, stx);
      r0 = rises;
      cycles(60);
      chk(rises == r0 && sck_out, "R5", "clock masked after end", rises - r0, 0);
      set_gens(2'b00);
   endtask

   task automatic t_wrong_tick(input logic [1:0] m);
      int f0;
      mode = m; slave_tx = 8'h5A; base = rises; f0 = falls;
      run8 = (m == 2'b10); run16 = (m == 2'b11); runt = 1'b0;
      pulse_write(8'hC3);
      cycles(80);
      chk(falls == f0, "R10", "unselected tick moved clock", falls - f0, 0);
      set_gens(m);
      wait_irq(600);
      cycles(1);
      chk(mon_cap == 8'hC3 && rdata == 8'h5A, "R10", "selected tick completes",
          rdata, 8'h5A);
      set_gens(2'b00);
   endtask

   task automatic t_ext(input logic [7:0] mtx, input logic [7:0] stx);
      mode = 2'b00; ext_drv = 1'b1; sck_in = 1'b1;
      cycles(4);
      pulse_write(mtx);
      chk(sck_oe == 1'b0, "R11", "sck_oe in external mode", sck_oe, 0);
      for (int i = 7; i >= 0; i--) begin
         sck_in = 1'b0;
         cycles(2);
         si_ext = stx[i];
         cycles(6);
         chk(so == mtx[i], "R3", "external mode output bit", so, mtx[i]);
         sck_in = 1'b1;
         cycles(8);
      end
      chk(irq == 1'b1, "R11", "irq after external transfer", irq, 1);
      chk(rdata == stx, "R11", "external received byte", rdata, stx);
      ext_drv = 1'b0;
   endtask

   task automatic t_ignore_mid;
      mode = 2'b11; slave_tx = 8'h3C; base = rises;
      set_gens(2'b11);
      pulse_write(8'hA5);
      for (int i = 0; i < 400 && (rises - base) < 3; i++) @(negedge clk);
      pulse_write(8'hFF);
      so_set = 1'b1; @(negedge clk); so_set = 1'b0;
      so_clr = 1'b1; @(negedge clk); so_clr = 1'b0;
      wait_irq(600);
      cycles(1);
      chk(mon_cap == 8'hA5, "R8", "strobes ignored mid-transfer", mon_cap, 8'hA5);
      chk(rdata == 8'h3C, "R7", "mid-transfer write ignored", rdata, 8'h3C);
      set_gens(2'b00);
   endtask

   task automatic t_irq_clear;
      cycles(10);
      chk(irq == 1'b1, "R6", "irq holds", irq, 1);
      irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b0, "R6", "irq cleared by strobe", irq, 0);
      t_xfer_int(2'b11, 8'h81, 8'h18);
      mode = 2'b11;
      pulse_write(8'h42);
      chk(irq == 1'b0, "R6", "irq cleared by new start", irq, 0);
   endtask

   task automatic t_disable;
      logic [7:0] keep;
      int r0;
      set_gens(2'b11);
      cycles(20);
      enable = 1'b0;
      cycles(2);
      chk(sck_out == 1'b1 && sck_oe == 1'b0, "R9", "abort returns clock high",
          sck_out, 1);
      enable = 1'b1;
      r0 = rises;
      cycles(60);
      chk(rises == r0 && irq == 1'b0, "R9", "no resume or irq after abort",
          rises - r0, 0);
      set_gens(2'b00);
      keep = rdata;
      enable = 1'b0;
      pulse_write(8'h77);
      cycles(2);
      chk(rdata == keep, "R9", "write while disabled", rdata, keep);
      enable = 1'b1;
      set_gens(2'b11);
      r0 = rises;
      cycles(60);
      chk(rises == r0, "R9", "no transfer from disabled write", rises - r0, 0);
      set_gens(2'b00);
   endtask

   task automatic run_all;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset_state();
      enable = 1'b1;
      cycles(2);
      t_so_latch();
      t_xfer_int(2'b11, 8'hB4, 8'h69);
      t_xfer_int(2'b10, 8'h0F, 8'hF0);
      t_xfer_int(2'b01, 8'h96, 8'hE1);
      t_wrong_tick(2'b11);
      t_wrong_tick(2'b10);
      t_ext(8'h2D, 8'hD2);
      t_ignore_mid();
      t_irq_clear();
      t_disable();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule